// File: doc/BRIEF.md
# Per-Source Row Batch Former

This block is the front stage of a staged memory scheduler. Requests arrive one per cycle, each with a source number, a bank, a row, a column and a read/write bit. Each request either goes straight out on a bypass path toward the per-bank command queues, or is written into a small queue owned by its source. Inside each source queue, back-to-back requests to the same DRAM row are grouped into a row batch. A batch stays open until it is closed, and only closed batches are shown to the downstream batch scheduler.

A batch closes for one of three reasons. A request to a different row arrives. The batch has been open too long, and the limit is shorter for sources marked low-intensity. Or the queue has no free slot. The downstream scheduler sees the oldest entry of each queue together with a flag that marks the last entry of its batch. It pops entries one at a time, always in arrival order.

A request skips batching when its source queue is empty and either the source is marked low-intensity or the command queues hold few requests. A source with queued requests never bypasses, so the order within a source is kept.

Top module: `row_batch_former`

## Requirements
- R1: Requests that are not bypassed are written into their own source's queue and leave it oldest first. Each source's head is exposed on `hd_bank`, `hd_row`, `hd_col` and `hd_wr`, in the slice `[s*W +: W]`.
- R2: Consecutive queued requests from one source to the same row form a single batch. `hd_last[s]` is 1 only on the final entry of the head batch.
- R3: A queued request whose row differs from the open batch closes that batch in the same cycle. The new request becomes the first entry of a new batch, so the closed batch is ready after that clock edge.
- R4: An open batch becomes ready at the (T+1)th rising edge after the edge that wrote its first entry. T is `AGE_LO` (default 50) when the source's `src_low_int` bit is 1 and `AGE_HI` (default 200) otherwise, taken from the bit's current value.
- R5: When a source queue holds `DEPTH` entries, its open batch is closed. `in_ready` is 0 while `in_src` names that full queue.
- R6: Once a batch is closed, a later request to the same row starts a new batch.
- R7: A request whose source has `src_low_int` = 1 and an empty queue appears on `byp_valid` in the same cycle and is not queued.
- R8: A request from any source with an empty queue is bypassed when `cmdq_occ` is below `BYP_LIMIT` (default 16). At 16 and above, it is queued instead.
- R9: A request whose source queue is not empty is never bypassed.
- R10: `hd_valid[s]` is 1 only while the head entry of queue s belongs to a closed batch. Each cycle with `deq[s]` high removes one head entry.
- R11: After reset, every queue is empty, no `hd_valid` bit is set and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle |
| in_src | input | SRC_W | Source number |
| in_bank | input | BANK_W | Bank address |
| in_row | input | ROW_W | Row address |
| in_col | input | COL_W | Column address |
| in_wr | input | 1 | 1 for write, 0 for read |
| src_low_int | input | NUM_SRC | Per-source low-intensity flag |
| cmdq_occ | input | OCC_W | Total requests held in the per-bank command queues |
| byp_valid | output | 1 | Request forwarded on the bypass path |
| byp_src | output | SRC_W | Bypassed request source |
| byp_bank | output | BANK_W | Bypassed request bank |
| byp_row | output | ROW_W | Bypassed request row |
| byp_col | output | COL_W | Bypassed request column |
| byp_wr | output | 1 | Bypassed request write bit |
| hd_valid | output | NUM_SRC | Head entry of queue belongs to a closed batch |
| hd_last | output | NUM_SRC | Head entry ends its batch |
| hd_bank | output | NUM_SRC*BANK_W | Head bank per source |
| hd_row | output | NUM_SRC*ROW_W | Head row per source |
| hd_col | output | NUM_SRC*COL_W | Head column per source |
| hd_wr | output | NUM_SRC | Head write bit per source |
| deq | input | NUM_SRC | Pop the head entry of a source queue |

## Verification
The assertions assume that `in_src` always names an existing source. They also assume that the downstream scheduler raises `deq[s]` only while `hd_valid[s]` is 1, and that the bypass path accepts every request it is offered. The bench keeps to these assumptions. It drives sources 0 to 3 only and pops a queue only after it has seen that queue's head valid. It sets `cmdq_occ` to 31 during the batching tests, so that bypass is decided only by the low-intensity flag and the queue state.

// File: rtl/rbf_pkg.sv
// Shared types for the row batch former.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package rbf_pkg;

    // Reason an open batch is closed in a given cycle (priority order)
    typedef enum logic [1:0] {
        CLOSE_NONE = 2'd0,
        CLOSE_ROW  = 2'd1,
        CLOSE_AGE  = 2'd2,
        CLOSE_FULL = 2'd3
    } close_cause_t;

endpackage

// File: rtl/rbf_src_fifo.sv
// One source queue that groups same-row entries into batches.
// Only entries of closed batches are visible at the head.
// Assumes: push is never raised while full; the owner gates it.
module rbf_src_fifo
    import rbf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DW     = 18,
    parameter int ROW_W  = 8,
    parameter int AGE_LO = 50,
    parameter int AGE_HI = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [ROW_W-1:0] push_row,
    input  logic          low_int,
    input  logic          pop,
    output logic          empty,
    output logic          full,
    output logic          head_valid,
    output logic          head_last,
    output logic [DW-1:0] head_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AMAX  = (AGE_HI > AGE_LO) ? AGE_HI : AGE_LO;
    localparam int AGE_W = $clog2(AMAX + 1);

    logic [DW-1:0]    mem  [DEPTH];
    logic [DEPTH-1:0] endf;
    logic [PTR_W-1:0] rd_ptr, wr_ptr, last_idx;
    logic [CNT_W-1:0] count, ready_cnt;
    logic [ROW_W-1:0] open_row;
    logic [AGE_W-1:0] age, thr;
    logic             open_b, pop_ok, close, start_new;
    close_cause_t     cause;

    // Status derived from occupancy
    always_comb begin
        empty      = (count == '0);
        full       = (count == CNT_W'(DEPTH));
        open_b     = (count != ready_cnt);
        head_valid = (ready_cnt != '0);
        pop_ok     = pop && head_valid;
        head_last  = endf[rd_ptr];
        head_data  = mem[rd_ptr];
        thr        = low_int ? AGE_W'(AGE_LO) : AGE_W'(AGE_HI);
        last_idx   = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
    end

    // Pick the close reason for the open batch this cycle
    always_comb begin
        cause = CLOSE_NONE;
        if (open_b) begin
            if (push && (push_row != open_row)) cause = CLOSE_ROW;
            else if (age >= thr)                cause = CLOSE_AGE;
            else if (full)                      cause = CLOSE_FULL;
        end
        close     = (cause != CLOSE_NONE);
        start_new = push && (close || !open_b);
    end

    // Entry storage and batch-end flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            endf <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr]  <= push_data;
                endf[wr_ptr] <= 1'b0;
            end
            if (close) endf[last_idx] <= 1'b1;
        end
    end

    // Pointers and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            count     <= '0;
            ready_cnt <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count     <= count + CNT_W'(push) - CNT_W'(pop_ok);
            ready_cnt <= (close ? count : ready_cnt) - CNT_W'(pop_ok);
        end
    end

    // Open batch row and age of its oldest entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row <= '0;
            age      <= '0;
        end else if (start_new) begin
            open_row <= push_row;
            age      <= '0;
        end else if (close) begin
            age <= '0;
        end else if (open_b && (age < AGE_W'(AMAX))) begin
            age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/rbf_route.sv
// Decides, for the current request, bypass versus queueing.
// Bypass needs an empty source queue so per-source order holds.
// Assumes in_src is below NUM_SRC.
module rbf_route #(
    parameter int NUM_SRC   = 4,
    parameter int SRC_W     = 2,
    parameter int OCC_W     = 6,
    parameter int BYP_LIMIT = 16
) (
    input  logic               in_valid,
    input  logic [SRC_W-1:0]   in_src,
    input  logic [NUM_SRC-1:0] src_low_int,
    input  logic [OCC_W-1:0]   cmdq_occ,
    input  logic [NUM_SRC-1:0] fifo_empty,
    input  logic [NUM_SRC-1:0] fifo_full,
    output logic               take_byp,
    output logic               in_ready,
    output logic [NUM_SRC-1:0] push_vec
);
    logic byp_ok;

    // Bypass eligibility and acceptance
    always_comb begin
        byp_ok   = fifo_empty[in_src] &&
                   (src_low_int[in_src] || (cmdq_occ < OCC_W'(BYP_LIMIT)));
        in_ready = byp_ok || !fifo_full[in_src];
        take_byp = in_valid && byp_ok;
    end

    // One write enable per source queue
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_push
        assign push_vec[s] = in_valid && !byp_ok && !fifo_full[s] &&
                             (in_src == SRC_W'(s));
    end
endmodule

// File: rtl/row_batch_former.sv
// Top: per-source row batching with a bypass path.
// Assumes the downstream scheduler pops only valid heads and
// that the bypass path always accepts.
module row_batch_former #(
    parameter int NUM_SRC   = 4,
    parameter int DEPTH     = 4,
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 8,
    parameter int COL_W     = 6,
    parameter int OCC_W     = 6,
    parameter int BYP_LIMIT = 16,
    parameter int AGE_LO    = 50,
    parameter int AGE_HI    = 200,
    localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [SRC_W-1:0]          in_src,
    input  logic [BANK_W-1:0]         in_bank,
    input  logic [ROW_W-1:0]          in_row,
    input  logic [COL_W-1:0]          in_col,
    input  logic                      in_wr,
    input  logic [NUM_SRC-1:0]        src_low_int,
    input  logic [OCC_W-1:0]          cmdq_occ,
    output logic                      byp_valid,
    output logic [SRC_W-1:0]          byp_src,
    output logic [BANK_W-1:0]         byp_bank,
    output logic [ROW_W-1:0]          byp_row,
    output logic [COL_W-1:0]          byp_col,
    output logic                      byp_wr,
    output logic [NUM_SRC-1:0]        hd_valid,
    output logic [NUM_SRC-1:0]        hd_last,
    output logic [NUM_SRC*BANK_W-1:0] hd_bank,
    output logic [NUM_SRC*ROW_W-1:0]  hd_row,
    output logic [NUM_SRC*COL_W-1:0]  hd_col,
    output logic [NUM_SRC-1:0]        hd_wr,
    input  logic [NUM_SRC-1:0]        deq
);
    localparam int DW = BANK_W + ROW_W + COL_W + 1;

    logic [NUM_SRC-1:0] fifo_empty, fifo_full, push_vec;
    logic [DW-1:0]      in_data;

    // Pack the request payload and mirror it on the bypass path
    always_comb begin
        in_data  = {in_bank, in_row, in_col, in_wr};
        byp_src  = in_src;
        byp_bank = in_bank;
        byp_row  = in_row;
        byp_col  = in_col;
        byp_wr   = in_wr;
    end

    rbf_route #(
        .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .OCC_W(OCC_W), .BYP_LIMIT(BYP_LIMIT)
    ) route_i (
        .in_valid(in_valid), .in_src(in_src), .src_low_int(src_low_int),
        .cmdq_occ(cmdq_occ), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .take_byp(byp_valid), .in_ready(in_ready), .push_vec(push_vec)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [DW-1:0] hdat;

        rbf_src_fifo #(
            .DEPTH(DEPTH), .DW(DW), .ROW_W(ROW_W),
            .AGE_LO(AGE_LO), .AGE_HI(AGE_HI)
        ) fifo_i (
            .clk(clk), .rst_n(rst_n),
            .push(push_vec[s]), .push_data(in_data), .push_row(in_row),
            .low_int(src_low_int[s]), .pop(deq[s]),
            .empty(fifo_empty[s]), .full(fifo_full[s]),
            .head_valid(hd_valid[s]), .head_last(hd_last[s]), .head_data(hdat)
        );

        // Unpack head payload into the per-source slices
        assign {hd_bank[s*BANK_W +: BANK_W], hd_row[s*ROW_W +: ROW_W],
                hd_col[s*COL_W +: COL_W], hd_wr[s]} = hdat;
    end
endmodule

// File: rtl/rbf_checker.sv
// Property checker for row_batch_former, attached by bind.
// Assumes in_src names an existing source and deq only hits valid heads.
module rbf_checker #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [SRC_W-1:0]   in_src,
    input logic [NUM_SRC-1:0] src_low_int,
    input logic               byp_valid,
    input logic [NUM_SRC-1:0] hd_valid,
    input logic [NUM_SRC-1:0] deq,
    input logic [NUM_SRC-1:0] fifo_empty,
    input logic [NUM_SRC-1:0] fifo_full
);
    assert_bypass_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && src_low_int[in_src] && fifo_empty[in_src] |-> byp_valid);

    assert_keep_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byp_valid |-> fifo_empty[in_src]);

    assert_stall_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full[in_src] |-> !in_ready);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !byp_valid |-> !fifo_full[in_src]);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_hold
        assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            hd_valid[s] && !deq[s] |=> hd_valid[s]);
    end
endmodule

bind row_batch_former rbf_checker #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .src_low_int(src_low_int), .byp_valid(byp_valid),
    .hd_valid(hd_valid), .deq(deq), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);

// File: tb/row_batch_former_tb_top.sv
`timescale 1ns/1ps
module row_batch_former_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready, in_wr = 1'b0;
    logic [1:0]  in_src = '0;
    logic [2:0]  in_bank = '0;
    logic [7:0]  in_row = '0;
    logic [5:0]  in_col = '0;
    logic [3:0]  src_low_int = '0;
    logic [5:0]  cmdq_occ = 6'd31;
    logic        byp_valid, byp_wr;
    logic [1:0]  byp_src;
    logic [2:0]  byp_bank;
    logic [7:0]  byp_row;
    logic [5:0]  byp_col;
    logic [3:0]  hd_valid, hd_last, hd_wr, deq = '0;
    logic [11:0] hd_bank;
    logic [31:0] hd_row;
    logic [23:0] hd_col;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    row_batch_former dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
        .in_wr(in_wr), .src_low_int(src_low_int), .cmdq_occ(cmdq_occ),
        .byp_valid(byp_valid), .byp_src(byp_src), .byp_bank(byp_bank),
        .byp_row(byp_row), .byp_col(byp_col), .byp_wr(byp_wr),
        .hd_valid(hd_valid), .hd_last(hd_last), .hd_bank(hd_bank),
        .hd_row(hd_row), .hd_col(hd_col), .hd_wr(hd_wr), .deq(deq)
    );

    typedef struct packed {
        logic [1:0] src;
        logic       low;
        logic [5:0] occ;
        logic [7:0] row;
        logic       byp;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{2'd0, 1'b1, 6'd20, 8'd5, 1'b1},   // R7 low source, empty
        '{2'd1, 1'b0, 6'd3,  8'd5, 1'b1},   // R8 light load
        '{2'd2, 1'b0, 6'd16, 8'd7, 1'b0},   // R8 at limit: queued
        '{2'd2, 1'b1, 6'd20, 8'd7, 1'b0},   // R9 low but queue busy
        '{2'd2, 1'b0, 6'd0,  8'd7, 1'b0},   // R9 light load but busy
        '{2'd3, 1'b0, 6'd15, 8'd9, 1'b1},   // R8 just below limit
        '{2'd3, 1'b0, 6'd16, 8'd9, 1'b0}    // R8 at limit
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int s, input int row, input int col);
        @(negedge clk);
        in_valid = 1'b1; in_src = 2'(s); in_row = 8'(row); in_col = 6'(col);
        in_bank = 3'(s); in_wr = col[0];
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop(input int s);
        deq[s] = 1'b1;
        @(negedge clk);
        deq[s] = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 hd_valid", int'(hd_valid), 0);
        chk("R11 in_ready", int'(in_ready), 1);

        // Table of bypass decisions (R7, R8, R9)
        foreach (VEC[i]) begin
            @(negedge clk);
            in_valid = 1'b1; in_src = VEC[i].src; in_row = VEC[i].row;
            cmdq_occ = VEC[i].occ;
            src_low_int = VEC[i].low ? (4'b1 << VEC[i].src) : 4'b0;
            #1;
            chk($sformatf("R7/R8/R9 vec%0d byp_valid", i), int'(byp_valid), int'(VEC[i].byp));
            chk($sformatf("R7/R8/R9 vec%0d in_ready", i), int'(in_ready), 1);
            if (VEC[i].byp) chk("R7 byp_row", int'(byp_row), int'(VEC[i].row));
            @(negedge clk);
            in_valid = 1'b0; src_low_int = '0;
        end

        do_reset();
        cmdq_occ = 6'd31;

        // R1 R2 R3: rows 10,10,11 on source 0
        push(0, 10, 1); push(0, 10, 2);
        chk("R2 open batch hidden", int'(hd_valid[0]), 0);
        push(0, 11, 3);
        chk("R3 batch ready on row change", int'(hd_valid[0]), 1);
        chk("R1 head row", int'(hd_row[7:0]), 10);
        chk("R1 head col oldest", int'(hd_col[5:0]), 1);
        chk("R2 first not last", int'(hd_last[0]), 0);
        pop(0);
        chk("R1 second col", int'(hd_col[5:0]), 2);
        chk("R2 batch end flag", int'(hd_last[0]), 1);
        pop(0);
        chk("R10 open row11 hidden", int'(hd_valid[0]), 0);

        // R5: fill source 1
        for (int k = 0; k < 4; k++) push(1, 20, k);
        in_src = 2'd1;
        #1;
        chk("R5 in_ready low when full", int'(in_ready), 0);
        @(negedge clk);
        chk("R5 full closes batch", int'(hd_valid[1]), 1);
        for (int k = 0; k < 4; k++) begin
            chk("R10 drain col", int'(hd_col[11:6]), k);
            chk("R2 last flag", int'(hd_last[1]), (k == 3) ? 1 : 0);
            pop(1);
        end
        chk("R10 drained", int'(hd_valid[1]), 0);
        chk("R5 in_ready after drain", int'(in_ready), 1);

        // R4 high threshold and R6 same-row new batch on source 2
        push(2, 30, 0);
        repeat (200) @(negedge clk);
        chk("R4 high not yet ready", int'(hd_valid[2]), 0);
        @(negedge clk);
        chk("R4 high ready", int'(hd_valid[2]), 1);
        push(2, 30, 5);
        chk("R6 closed batch ends at first", int'(hd_last[2]), 1);
        chk("R6 head col", int'(hd_col[17:12]), 0);
        pop(2);
        chk("R6 same row new open batch", int'(hd_valid[2]), 0);

        // R4 low threshold on source 3
        push(3, 40, 0);
        src_low_int = 4'b1000;
        repeat (50) @(negedge clk);
        chk("R4 low not yet ready", int'(hd_valid[3]), 0);
        @(negedge clk);
        chk("R4 low ready", int'(hd_valid[3]), 1);
        chk("R4 low head row", int'(hd_row[31:24]), 40);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule